// File: doc/BRIEF.md
# Hex Record Image Loader

This block takes a stream of ASCII characters, one per cycle in which its strobe is high, and turns hex-encoded load records into byte writes on a simple memory write port. A record opens with a colon. It then carries a 16-bit load address, a byte count, a checksum over that header, the data bytes and a checksum over the data, and it closes with a carriage return. Each data byte leaves the block as a one-cycle write pulse carrying an address and a byte. The address starts at the load address and steps by one for each byte.

A large image arrives as a series of records, each holding at most 255 bytes. Loading ends when a record with a zero byte count arrives. In that record the address field is the program entry point, and the block presents it together with a one-cycle done pulse. Malformed records raise a one-cycle format-error pulse. Checksum mismatches raise a one-cycle checksum-error pulse. In both cases the parser returns to hunting for the next colon.

The control is a single state machine with these states: ST_HUNT (waiting for a colon), ST_ADDR, ST_LEN, ST_HSUM, ST_DATA, ST_DSUM (reading the fields), ST_EOL (waiting for carriage return) and ST_FIN (load complete). The transitions are:
- ST_HUNT to ST_ADDR on a colon.
- ST_ADDR to ST_LEN after the last address digit.
- ST_LEN to ST_FIN on a zero count, or to ST_HSUM otherwise.
- ST_HSUM to ST_DATA on a matching header checksum, or to ST_HUNT on a mismatch.
- ST_DATA to ST_DSUM after the last data byte.
- ST_DSUM to ST_EOL after the checksum.
- ST_EOL to ST_HUNT on carriage return.
- Any field state, or ST_EOL, goes to ST_HUNT on an illegal character. If that character is a colon it goes to ST_ADDR instead.
- ST_FIN holds until reset.

Top module: `tape_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, wr_en, done, fmt_err and sum_err are low, entry_addr is zero, and the parser is hunting for a colon.
- R2: While hunting, every character other than a colon (0x3A) is ignored, including line feeds (0x0A) that follow a record's carriage return.
- R3: A character is taken only in a cycle where ch_valid is high. With ch_valid low there is no write, done or error pulse, and the parse position does not move.
- R4: After the colon come four address digits (most significant first), two count digits, two header-checksum digits, two digits per data byte and two data-checksum digits. Hex digits are 0x30-0x39 and 0x41-0x46 only. Each data byte produces wr_en for one cycle, starting the cycle after its second digit is taken. wr_addr starts at the load address and increments by one per byte, wrapping modulo 2^16.
- R5: The header checksum is the XOR of the address high byte, the address low byte and the count byte. On a mismatch, sum_err pulses for one cycle after the second checksum digit, no data byte of that record is written, and the parser hunts again.
- R6: The data checksum is the XOR of all data bytes of the record. On a mismatch, sum_err pulses for one cycle after its second digit. Bytes already written stay written.
- R7: A non-hex character in a field, or any character other than carriage return (0x0D) right after the data checksum, pulses fmt_err for one cycle and abandons the record. If that character is a colon, it starts a new record.
- R8: A record with a zero count pulses done for one cycle, starting the cycle after its second count digit. entry_addr is set to the address field and then held. After that all input is ignored until reset.
- R9: Consecutive records each load at their own address, independent of the records before them.
- R10: At most one of wr_en, done, fmt_err and sum_err is high in any cycle, and wr_en is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | 1 | ch_data holds a character this cycle |
| ch_data | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle memory write strobe |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data byte |
| done | output | 1 | One-cycle pulse on the end record |
| entry_addr | output | 16 | Program entry address from the end record |
| fmt_err | output | 1 | One-cycle pulse on a malformed record |
| sum_err | output | 1 | One-cycle pulse on a checksum mismatch |

## Verification
The bench targets these corner cases:
- A header checksum that fails. A design that ignored the failure would write the whole payload.
- A data checksum that fails after its bytes have already gone out. A design that flagged the error at the wrong place would pulse sum_err early or not at all.
- A record starting at 0xFFFE. A design without proper wrap would produce addresses beyond 16 bits or repeat an address.
- Lowercase digits, a stray colon inside a record, and a missing carriage return. Each must raise fmt_err, and the stray colon must restart parsing at once rather than wait for another colon.
- Strobe gaps in the middle of a field, which would shift the digit position in a design that counted cycles instead of characters.
- Records sent after the end record, which must produce nothing.

// File: rtl/tl_pkg.sv
package tl_pkg;
    localparam logic [7:0] CH_COLON = 8'h3A;
    localparam logic [7:0] CH_CR    = 8'h0D;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_ADDR,
        ST_LEN,
        ST_HSUM,
        ST_DATA,
        ST_DSUM,
        ST_EOL,
        ST_FIN
    } tl_state_e;
endpackage

// File: rtl/tl_hexdec.sv
module tl_hexdec (
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    always_comb begin
        is_hex = 1'b0;
        nib    = 4'h0;
        if (ch >= 8'h30 && ch <= 8'h39) begin
            is_hex = 1'b1;
            nib    = ch[3:0];
        end else if (ch >= 8'h41 && ch <= 8'h46) begin
            is_hex = 1'b1;
            nib    = ch[3:0] + 4'd9;
        end
    end
endmodule

// File: rtl/tl_xorsum.sv
module tl_xorsum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum <= '0;
        else if (clr) sum <= '0;
        else if (en)  sum <= sum ^ din;
    end
endmodule

// File: rtl/tape_loader.sv
module tape_loader #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_valid,
    input  logic [7:0]        ch_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              fmt_err,
    output logic              sum_err
);
    import tl_pkg::*;

    localparam int ADDR_DIGITS = ADDR_W / 4;
    localparam int DIG_W       = (ADDR_DIGITS > 2) ? $clog2(ADDR_DIGITS) : 1;
    localparam logic [DIG_W-1:0] LAST_ADDR_DIG = DIG_W'(ADDR_DIGITS - 1);

    tl_state_e         state_q, state_d;
    logic [DIG_W-1:0]  dig_q;
    logic [3:0]        hi_nib_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        cnt_q;

    logic       is_hex;
    logic [3:0] nib;
    logic [7:0] byte_v;
    logic [7:0] sum;
    logic       in_field, good_dig, bad_ch, start, byte_end, addr_end;
    logic       sum_clr, sum_en;

    tl_hexdec u_hexdec (
        .ch     (ch_data),
        .is_hex (is_hex),
        .nib    (nib)
    );

    assign byte_v   = {hi_nib_q, nib};
    assign in_field = (state_q == ST_ADDR) || (state_q == ST_LEN) ||
                      (state_q == ST_HSUM) || (state_q == ST_DATA) ||
                      (state_q == ST_DSUM);
    assign good_dig = ch_valid && in_field && is_hex;
    assign bad_ch   = ch_valid && ((in_field && !is_hex) ||
                      ((state_q == ST_EOL) && (ch_data != CH_CR)));
    assign start    = ch_valid && (ch_data == CH_COLON) &&
                      ((state_q == ST_HUNT) || bad_ch);
    assign byte_end = good_dig && dig_q[0];
    assign addr_end = good_dig && (state_q == ST_ADDR) && (dig_q == LAST_ADDR_DIG);

    assign sum_clr = start || (byte_end && (state_q == ST_HSUM));
    assign sum_en  = byte_end && ((state_q == ST_ADDR) || (state_q == ST_LEN) ||
                                  (state_q == ST_DATA));

    tl_xorsum #(.W(8)) u_xorsum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .en    (sum_en),
        .din   (byte_v),
        .sum   (sum)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: if (start) state_d = ST_ADDR;
            ST_ADDR: if (addr_end) state_d = ST_LEN;
            ST_LEN:  if (byte_end) state_d = (byte_v == 8'h00) ? ST_FIN : ST_HSUM;
            ST_HSUM: if (byte_end) state_d = (byte_v == sum) ? ST_DATA : ST_HUNT;
            ST_DATA: if (byte_end && cnt_q == 8'd1) state_d = ST_DSUM;
            ST_DSUM: if (byte_end) state_d = ST_EOL;
            ST_EOL:  if (ch_valid && ch_data == CH_CR) state_d = ST_HUNT;
            ST_FIN:  state_d = ST_FIN;
            default: state_d = ST_HUNT;
        endcase
        if (bad_ch) state_d = (ch_data == CH_COLON) ? ST_ADDR : ST_HUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_q      <= '0;
            hi_nib_q   <= '0;
            addr_q     <= '0;
            cnt_q      <= '0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done       <= 1'b0;
            entry_addr <= '0;
            fmt_err    <= 1'b0;
            sum_err    <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            done    <= 1'b0;
            fmt_err <= 1'b0;
            sum_err <= 1'b0;
            if (start) dig_q <= '0;
            if (bad_ch) fmt_err <= 1'b1;
            if (good_dig) begin
                if (!dig_q[0]) hi_nib_q <= nib;
                if (state_q == ST_ADDR) begin
                    addr_q <= {addr_q[ADDR_W-5:0], nib};
                    dig_q  <= addr_end ? '0 : dig_q + 1'b1;
                end else begin
                    dig_q <= dig_q[0] ? '0 : dig_q + 1'b1;
                end
            end
            if (byte_end) begin
                unique case (state_q)
                    ST_LEN: begin
                        cnt_q <= byte_v;
                        if (byte_v == 8'h00) begin
                            done       <= 1'b1;
                            entry_addr <= addr_q;
                        end
                    end
                    ST_HSUM: if (byte_v != sum) sum_err <= 1'b1;
                    ST_DATA: begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr_q;
                        wr_data <= byte_v;
                        addr_q  <= addr_q + 1'b1;
                        cnt_q   <= cnt_q - 8'd1;
                    end
                    ST_DSUM: if (byte_v != sum) sum_err <= 1'b1;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tape_loader_chk.sv
module tape_loader_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ch_valid,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              done,
    input logic              fmt_err,
    input logic              sum_err,
    input tl_pkg::tl_state_e state_q,
    input logic [ADDR_W-1:0] addr_q
);
    import tl_pkg::*;

    a_r3_no_strobe_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> !(wr_en || done || fmt_err || sum_err));

    a_r10_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, done, fmt_err, sum_err}));

    a_r10_write_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr_q == wr_addr + 1'b1));

    a_r2_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |=> !(wr_en || done || fmt_err || sum_err));

    a_r8_done_final: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_FIN));

    a_r8_fin_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |=> !(wr_en || done || fmt_err || sum_err));
endmodule

bind tape_loader tape_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_valid (ch_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .done     (done),
    .fmt_err  (fmt_err),
    .sum_err  (sum_err),
    .state_q  (state_q),
    .addr_q   (addr_q)
);

// File: tb/tape_loader_bench.sv
`timescale 1ns/1ps
module tape_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_valid = 1'b0;
    logic [7:0]  ch_data = 8'h00;
    logic        wr_en, done, fmt_err, sum_err;
    logic [15:0] wr_addr, entry_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // reference model state
    int m_mode, m_k, m_addr, m_len, m_hi, m_sum, m_wa;
    int e_wr, e_wa, e_wd, e_done, e_entry, e_fmt, e_sum;
    int pay [0:255];

    always #2.5 clk = ~clk;

    tape_loader u_tape_loader (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done),
        .entry_addr(entry_addr), .fmt_err(fmt_err), .sum_err(sum_err)
    );

    function automatic int hexv(input int c);
        if (c >= 48 && c <= 57) return c - 48;
        if (c >= 65 && c <= 70) return c - 55;
        return -1;
    endfunction

    function automatic int hexc(input int v);
        return (v < 10) ? 48 + v : 55 + v;
    endfunction

    task automatic model_reset();
        m_mode = 0; m_k = 0; m_addr = 0; m_len = 0; m_hi = 0; m_sum = 0; m_wa = 0;
        e_wr = 0; e_wa = 0; e_wd = 0; e_done = 0; e_entry = 0; e_fmt = 0; e_sum = 0;
    endtask

    task automatic model_start();
        m_mode = 1; m_k = 0; m_addr = 0;
    endtask

    task automatic model_step(input int valid, input int c);
        int v, k, b;
        e_wr = 0; e_done = 0; e_fmt = 0; e_sum = 0;
        if (valid == 0) return;
        if (m_mode == 0) begin
            if (c == 58) model_start();
        end else if (m_mode == 1) begin
            v = hexv(c);
            if (v < 0) begin
                e_fmt = 1;
                if (c == 58) model_start(); else m_mode = 0;
            end else begin
                k = m_k; m_k++;
                b = (m_hi << 4) | v;
                if ((k % 2) == 0) m_hi = v;
                if (k < 4) m_addr = ((m_addr << 4) | v) & 16'hFFFF;
                else if (k == 5) begin
                    m_len = b;
                    if (m_len == 0) begin e_done = 1; e_entry = m_addr; m_mode = 3; end
                end else if (k == 7) begin
                    if (b != (((m_addr >> 8) ^ m_addr ^ m_len) & 255)) begin
                        e_sum = 1; m_mode = 0;
                    end else begin
                        m_wa = m_addr; m_sum = 0;
                    end
                end else if (k >= 8 && k < 8 + 2*m_len) begin
                    if ((k % 2) == 1) begin
                        e_wr = 1; e_wa = m_wa; e_wd = b;
                        m_wa = (m_wa + 1) & 16'hFFFF; m_sum = m_sum ^ b;
                    end
                end else if (k == 9 + 2*m_len) begin
                    if (b != m_sum) e_sum = 1;
                    m_mode = 2;
                end
            end
        end else if (m_mode == 2) begin
            if (c == 13) m_mode = 0;
            else begin
                e_fmt = 1;
                if (c == 58) model_start(); else m_mode = 0;
            end
        end
    endtask

    task automatic cmp(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp("wr_en", int'(wr_en), e_wr);
        cmp("done", int'(done), e_done);
        cmp("fmt_err", int'(fmt_err), e_fmt);
        cmp("sum_err", int'(sum_err), e_sum);
        cmp("entry_addr", int'(entry_addr), e_entry);
        if (e_wr != 0) begin
            cmp("wr_addr", int'(wr_addr), e_wa);
            cmp("wr_data", int'(wr_data), e_wd);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ch_valid = 1'b0;
        model_step(0, 0);
        @(posedge clk); #1;
        compare_all();
    endtask

    task automatic send_ch(input int c, input int gap);
        @(negedge clk);
        ch_valid = 1'b1;
        ch_data  = 8'(c);
        model_step(1, c);
        @(posedge clk); #1;
        compare_all();
        for (int g = 0; g < gap; g++) idle();
    endtask

    task automatic send_byte(input int b, input int gap);
        send_ch(hexc((b >> 4) & 15), gap);
        send_ch(hexc(b & 15), gap);
    endtask

    task automatic send_rec(input int addr, input int n, input int hs_flip,
                            input int ds_flip, input int gap);
        int hs, ds;
        hs = ((addr >> 8) ^ addr ^ n) & 255;
        ds = 0;
        for (int i = 0; i < n; i++) ds = ds ^ pay[i];
        send_ch(58, gap);
        send_byte((addr >> 8) & 255, gap);
        send_byte(addr & 255, gap);
        send_byte(n, gap);
        send_byte(hs ^ hs_flip, gap);
        for (int i = 0; i < n; i++) send_byte(pay[i], gap);
        send_byte(ds ^ ds_flip, gap);
        send_ch(13, gap);
        send_ch(10, gap);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ch_valid = 1'b0;
        model_reset();
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); #1;
            compare_all();
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        do_reset();
        idle();

        // R2: noise before a colon, including line feeds
        cur_req = "R2";
        send_ch(120, 0); send_ch(10, 0); send_ch(13, 0); send_ch(65, 0); send_ch(48, 0);

        // R4: basic record
        cur_req = "R4";
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33;
        send_rec(16'h1000, 3, 0, 0, 0);

        // R9: following record at its own address
        cur_req = "R9";
        pay[0] = 8'hAB; pay[1] = 8'hCD;
        send_rec(16'h2040, 2, 0, 0, 0);

        // R3: strobe gaps inside fields
        cur_req = "R3";
        pay[0] = 8'h5A; pay[1] = 8'hF0;
        send_rec(16'h0300, 2, 0, 0, 2);

        // R5: header checksum mismatch, nothing written
        cur_req = "R5";
        pay[0] = 8'h01; pay[1] = 8'h02;
        send_rec(16'h0500, 2, 8'h40, 0, 0);

        // R6: data checksum mismatch after writes
        cur_req = "R6";
        pay[0] = 8'h77; pay[1] = 8'h88; pay[2] = 8'h99;
        send_rec(16'h0600, 3, 0, 8'h01, 0);

        // R4: address wrap past 0xFFFF
        cur_req = "R4";
        pay[0] = 8'hE1; pay[1] = 8'hE2; pay[2] = 8'hE3;
        send_rec(16'hFFFE, 3, 0, 0, 0);

        // R7: lowercase hex digit abandons the record
        cur_req = "R7";
        send_ch(58, 0); send_ch(49, 0); send_ch(97, 0); send_ch(48, 0); send_ch(48, 0);
        // R7: colon inside a record restarts at once
        send_ch(58, 0); send_ch(55, 0);
        pay[0] = 8'h3C;
        send_rec(16'h0700, 1, 0, 0, 0);
        // R7: missing carriage return after data checksum
        pay[0] = 8'h10; pay[1] = 8'h20;
        send_ch(58, 0);
        send_byte(8'h08, 0); send_byte(8'h00, 0); send_byte(8'h02, 0);
        send_byte(8'h08 ^ 8'h02, 0);
        send_byte(8'h10, 0); send_byte(8'h20, 0); send_byte(8'h30, 0);
        send_ch(88, 0);
        send_ch(13, 0);

        // R10: longer record, writes spaced by two characters
        cur_req = "R10";
        for (int i = 0; i < 20; i++) pay[i] = (i * 37 + 5) & 255;
        send_rec(16'h1200, 20, 0, 0, 0);

        // R8: end record and silence afterwards
        cur_req = "R8";
        send_ch(58, 0);
        send_ch(48, 0); send_ch(52, 0); send_ch(52, 0); send_ch(48, 0);
        send_ch(48, 0); send_ch(48, 0);
        idle();
        pay[0] = 8'h99;
        send_rec(16'h0800, 1, 0, 0, 0);
        send_ch(103, 0);
        idle();

        // R1: reset clears entry address
        cur_req = "R1";
        do_reset();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule